// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five numbered requester contexts ("localities") owns a shared command interface at any moment. Each locality has a one-byte access register on a byte-addressable register bus. The locality number comes from address bits [14:12], and the access register sits at offset 0 within each locality's window. Software in a locality writes this register to ask for ownership, to give it up, or to take it by force, and it reads the register to see whether it owns the interface, whether it was pushed out, and whether anyone else is waiting. The block keeps the current owner, a request flag, a hidden seize flag and a sticky been-seized flag for each locality, and it exports the owner number to the command engine.

Ownership changes in one of three ways. A locality can be granted ownership at once when the interface is free. The owner can release the interface, and it then passes to the highest-numbered waiting locality. A higher-numbered locality can seize the interface from the current owner. If the command engine is busy when a handover is due, the block raises an abort request and holds the handover until the engine answers with abort-done. A one-cycle locality-changed pulse marks each new owner so that an interrupt unit can act on it.

The control state machine has three states. FREE means no locality owns the interface. OWNED means a locality owns it. ABORT means a handover waits for the engine. Its transitions are:
- grant (FREE to OWNED), on a request or seize write.
- release-empty (OWNED to FREE), when the owner releases and nobody waits.
- handover (OWNED to OWNED), when the engine is idle.
- defer (OWNED to ABORT), when a handover is due and the engine is busy.
- retarget (ABORT to ABORT), when a stronger seize arrives during an abort.
- complete (ABORT to OWNED), on abort-done.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality is active (active_loc reads 7), abort_req and loc_chg are low, and the access register of every locality 0 to 4 reads 0x80.
- R2: An access read returns bit 7 = 1, bit 5 = the reader is the owner, bit 4 = been-seized, bit 2 = pending, bit 1 = request flag, and bit 0 = the estab_in input. Bits 6 and 3 read 0, so the seize flag is never visible.
- R3: The pending bit (bit 2) seen by locality N is 1 exactly when some locality other than N has its request flag set.
- R4: A write with bit 1 set, from a locality that is not the owner, grants ownership at once if no locality is active. If another locality is active, the write sets the writer's request flag instead.
- R5: When the owner writes bit 5 = 1, ownership passes to the highest-numbered locality with its request flag set. If none is waiting, no locality is active afterwards.
- R6: When a non-owner writes bit 5 = 1, only that locality's own request flag is cleared and ownership is unchanged.
- R7: A seize write (bit 3) is accepted only if no locality is active or the writer's number is above the owner's. It is refused if the writer already has a seize pending or a higher locality has one. An accepted seize clears the seize flags of all lower localities, and at most one seize flag is ever set.
- R8: In a write with bit 3 set, bits 1 and 5 are ignored.
- R9: On a handover the new owner's request and seize flags are cleared. After a seizure the old owner gets been-seized set and keeps its request flag. After a release the old owner's request flag is cleared.
- R10: Writing 1 to bit 4 clears the writer's been-seized flag.
- R11: Each change to a new valid owner produces a one-cycle loc_chg pulse in the cycle in which active_loc first shows that owner. Loc_chg stays low when ownership ends with no successor.
- R12: Writes from locality 4 take effect only when bus_hw is 1. Writes to localities 5 to 7, and writes to a non-zero offset, are ignored. Reads of those addresses return 0xFF. active_loc only ever holds 0 to 4 or 7.
- R13: A handover due while a locality is active and cmd_busy is 1 raises abort_req one cycle after the write and leaves the owner unchanged. Abort_req stays high until abort_done is seen, and the handover then completes in that same edge. During the abort a later accepted seize replaces the pending target, and an owner's release is ignored.
- R14: The locality number is taken from address bits [14:12], and the access register is selected when bits [11:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 15 | Byte address; [14:12] locality, [11:0] offset |
| bus_wdata | input | 8 | Write data |
| bus_hw | input | 1 | Write comes from the privileged hardware path |
| bus_rdata | output | 8 | Combinational read data of the addressed access register |
| estab_in | input | 1 | Level reflected in read bit 0 |
| cmd_busy | input | 1 | Command engine is executing |
| abort_done | input | 1 | Engine finished aborting |
| active_loc | output | 3 | Current owner, 7 when none |
| loc_chg | output | 1 | One-cycle pulse on a new owner |
| abort_req | output | 1 | Handover waits for the engine to abort |

## Verification
The assertions assume that abort_done is pulsed only while abort_req is high, and that cmd_busy is never asserted while the interface is free. The bench raises cmd_busy only after a grant and drops it before the owner releases to nobody. It pulses abort_done for one cycle only after it has seen abort_req. The bench never writes in the same cycle as abort_done, so the retarget and complete transitions are driven in separate cycles.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
    localparam int LOC_W = 3;
    localparam int NSLOT = 1 << LOC_W;
    localparam logic [LOC_W-1:0] LOC_NONE = 3'd7;

    localparam int B_VALID = 7;
    localparam int B_ACT   = 5;
    localparam int B_BEEN  = 4;
    localparam int B_SEIZE = 3;
    localparam int B_PEND  = 2;
    localparam int B_REQ   = 1;
    localparam int B_EST   = 0;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_OWNED = 2'd1,
        ST_ABORT = 2'd2
    } arb_state_e;
endpackage

// File: rtl/locarb_decode.sv
module locarb_decode
    import locarb_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int LOC_LSB = 12,
    parameter int NUM_LOC = 5,
    parameter int HW_LOC  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              hw,
    output logic [LOC_W-1:0]  loc,
    output logic              loc_ok,
    output logic              reg_hit,
    output logic              wr_ok
);
    assign loc     = addr[LOC_LSB +: LOC_W];
    assign loc_ok  = (int'(loc) < NUM_LOC);
    assign reg_hit = (addr[LOC_LSB-1:0] == '0);
    assign wr_ok   = wr && loc_ok && reg_hit && ((int'(loc) != HW_LOC) || hw);
endmodule

// File: rtl/locarb_prio.sv
module locarb_prio
    import locarb_pkg::*;
#(
    parameter int NUM_LOC = 5
) (
    input  logic [NSLOT-1:0] vec,
    output logic             found,
    output logic [LOC_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = LOC_NONE;
        for (int i = 0; i < NSLOT; i++) begin
            if (i < NUM_LOC && vec[i]) begin
                found = 1'b1;
                idx   = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/locarb_readback.sv
module locarb_readback
    import locarb_pkg::*;
#(
    parameter int NUM_LOC = 5
) (
    input  logic [LOC_W-1:0] loc,
    input  logic             sel_ok,
    input  logic [LOC_W-1:0] owner,
    input  logic [NSLOT-1:0] req,
    input  logic [NSLOT-1:0] been,
    input  logic             estab,
    output logic [7:0]       rdata
);
    logic pend;

    always_comb begin
        pend = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i < NUM_LOC && i != int'(loc) && req[i]) pend = 1'b1;
        end
    end

    always_comb begin
        rdata = 8'hFF;
        if (sel_ok) begin
            rdata          = 8'h00;
            rdata[B_VALID] = 1'b1;
            rdata[B_ACT]   = (owner == loc);
            rdata[B_BEEN]  = been[loc];
            rdata[B_PEND]  = pend;
            rdata[B_REQ]   = req[loc];
            rdata[B_EST]   = estab;
        end
    end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
    import locarb_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int LOC_LSB = 12,
    parameter int NUM_LOC = 5,
    parameter int HW_LOC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_hw,
    output logic [7:0]        bus_rdata,
    input  logic              estab_in,
    input  logic              cmd_busy,
    input  logic              abort_done,
    output logic [LOC_W-1:0]  active_loc,
    output logic              loc_chg,
    output logic              abort_req
);
    arb_state_e       st_q, st_n;
    logic [LOC_W-1:0] act_q, act_n, nxt_q, nxt_n;
    logic [NSLOT-1:0] req_q, req_n, sz_q, sz_n, bs_q, bs_n;
    logic             evt_q, evt_n;

    logic [LOC_W-1:0] wl;
    logic             wl_ok, wl_hit, wok;
    logic             pr_found;
    logic [LOC_W-1:0] pr_idx;
    logic [7:0]       wv;
    logic             hi_sz, seize_ok;
    logic             want_ho, hand;
    logic [LOC_W-1:0] ho_tgt, tgt;

    locarb_decode #(
        .ADDR_W (ADDR_W),
        .LOC_LSB(LOC_LSB),
        .NUM_LOC(NUM_LOC),
        .HW_LOC (HW_LOC)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .hw     (bus_hw),
        .loc    (wl),
        .loc_ok (wl_ok),
        .reg_hit(wl_hit),
        .wr_ok  (wok)
    );

    locarb_prio #(.NUM_LOC(NUM_LOC)) u_prio (
        .vec  (req_q),
        .found(pr_found),
        .idx  (pr_idx)
    );

    locarb_readback #(.NUM_LOC(NUM_LOC)) u_rb (
        .loc   (wl),
        .sel_ok(wl_ok && wl_hit),
        .owner (act_q),
        .req   (req_q),
        .been  (bs_q),
        .estab (estab_in),
        .rdata (bus_rdata)
    );

    // A seize write drops its request and release bits.
    always_comb begin
        wv = bus_wdata;
        if (wv[B_SEIZE]) begin
            wv[B_REQ] = 1'b0;
            wv[B_ACT] = 1'b0;
        end
    end

    always_comb begin
        hi_sz = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i > int'(wl) && sz_q[i]) hi_sz = 1'b1;
        end
    end

    assign seize_ok = ((act_q == LOC_NONE) || (wl > act_q)) && !sz_q[wl] && !hi_sz;

    // Next-state and flag update logic.
    always_comb begin
        st_n    = st_q;
        act_n   = act_q;
        nxt_n   = nxt_q;
        req_n   = req_q;
        sz_n    = sz_q;
        bs_n    = bs_q;
        evt_n   = 1'b0;
        want_ho = 1'b0;
        ho_tgt  = LOC_NONE;
        hand    = 1'b0;
        tgt     = LOC_NONE;

        if (wok) begin
            if (wv[B_ACT]) begin
                if (act_q == wl) begin
                    if (st_q != ST_ABORT) begin
                        if (pr_found) begin
                            want_ho = 1'b1;
                            ho_tgt  = pr_idx;
                        end else begin
                            act_n = LOC_NONE;
                            st_n  = ST_FREE;
                        end
                    end
                end else begin
                    req_n[wl] = 1'b0;
                end
            end
            if (wv[B_BEEN]) bs_n[wl] = 1'b0;
            if (wv[B_SEIZE] && seize_ok) begin
                for (int i = 0; i < NSLOT; i++) begin
                    if (i < int'(wl)) sz_n[i] = 1'b0;
                end
                sz_n[wl] = 1'b1;
                want_ho  = 1'b1;
                ho_tgt   = wl;
            end
            if (wv[B_REQ] && act_q != wl) begin
                if (act_q != LOC_NONE) begin
                    req_n[wl] = 1'b1;
                end else begin
                    want_ho = 1'b1;
                    ho_tgt  = wl;
                end
            end
        end

        unique case (st_q)
            ST_ABORT: begin
                if (want_ho) nxt_n = ho_tgt;
                if (abort_done) begin
                    hand = 1'b1;
                    tgt  = nxt_n;
                end
            end
            ST_FREE, ST_OWNED: begin
                if (want_ho) begin
                    if (act_q != LOC_NONE && cmd_busy) begin
                        st_n  = ST_ABORT;
                        nxt_n = ho_tgt;
                    end else begin
                        hand = 1'b1;
                        tgt  = ho_tgt;
                    end
                end
            end
            default: st_n = ST_FREE;
        endcase

        if (hand) begin
            if (act_q != LOC_NONE && act_q != tgt) begin
                if (sz_n[tgt]) bs_n[act_q]  = 1'b1;
                else           req_n[act_q] = 1'b0;
            end
            req_n[tgt] = 1'b0;
            sz_n[tgt]  = 1'b0;
            act_n      = tgt;
            st_n       = ST_OWNED;
            nxt_n      = LOC_NONE;
            evt_n      = (act_q != tgt);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FREE;
            act_q <= LOC_NONE;
            nxt_q <= LOC_NONE;
            req_q <= '0;
            sz_q  <= '0;
            bs_q  <= '0;
            evt_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            act_q <= act_n;
            nxt_q <= nxt_n;
            req_q <= req_n;
            sz_q  <= sz_n;
            bs_q  <= bs_n;
            evt_q <= evt_n;
        end
    end

    // Outputs.
    always_comb begin
        active_loc = act_q;
        loc_chg    = evt_q;
        abort_req  = (st_q == ST_ABORT);
    end

    // R13
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && !abort_done |=> abort_req);

    // R13
    abort_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && !abort_done |=> $stable(active_loc));

    // R11
    chg_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_chg |-> active_loc != LOC_NONE);

    // R11
    chg_moved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_chg |-> active_loc != $past(active_loc));

    // R7
    seize_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sz_q));

    // R12
    owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(active_loc) < NUM_LOC) || (active_loc == LOC_NONE));

    // R1
    free_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FREE) == (active_loc == LOC_NONE));
endmodule

// File: tb/test_locality_arbiter.sv
module test_locality_arbiter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_hw = 1'b0;
    logic [7:0]  bus_rdata;
    logic        estab_in = 1'b0;
    logic        cmd_busy = 1'b0;
    logic        abort_done = 1'b0;
    logic [2:0]  active_loc;
    logic        loc_chg;
    logic        abort_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    locality_arbiter i_locality_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_hw    (bus_hw),
        .bus_rdata (bus_rdata),
        .estab_in  (estab_in),
        .cmd_busy  (cmd_busy),
        .abort_done(abort_done),
        .active_loc(active_loc),
        .loc_chg   (loc_chg),
        .abort_req (abort_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_acc(input int loc, input logic [7:0] d,
                          input logic hw = 1'b0, input logic [11:0] off = 12'h000);
        @(negedge clk);
        bus_addr  = {3'(loc), off};
        bus_wdata = d;
        bus_hw    = hw;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_hw    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int loc, input int exp,
                          input logic [11:0] off = 12'h000);
        bus_addr = {3'(loc), off};
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic t_reset();
        check("R1 active after reset", int'(active_loc), 7);
        check("R1 abort_req after reset", int'(abort_req), 0);
        check("R1 loc_chg after reset", int'(loc_chg), 0);
        for (int i = 0; i < 5; i++) rd_chk("R1 access reset value", i, 8'h80);
        rd_chk("R12 read of locality 5", 5, 8'hFF);
        estab_in = 1'b1;
        rd_chk("R2 estab bit 0", 2, 8'h81);
        estab_in = 1'b0;
    endtask

    task automatic t_grant_pending();
        wr_acc(1, 8'h02);
        check("R4 grant when free", int'(active_loc), 1);
        check("R11 pulse on grant", int'(loc_chg), 1);
        rd_chk("R2 owner read", 1, 8'hA0);
        wr_acc(3, 8'h02);
        check("R4 owner kept on request", int'(active_loc), 1);
        check("R11 no pulse without change", int'(loc_chg), 0);
        rd_chk("R4 request flag set", 3, 8'h82);
        rd_chk("R3 pending seen by owner", 1, 8'hA4);
        wr_acc(0, 8'h02);
        rd_chk("R3 pending from other requester", 3, 8'h86);
        rd_chk("R3 pending plus own request", 0, 8'h86);
    endtask

    task automatic t_release();
        wr_acc(1, 8'h20);
        check("R5 release to highest requester", int'(active_loc), 3);
        check("R11 pulse on release handover", int'(loc_chg), 1);
        rd_chk("R9 old owner after release", 1, 8'h84);
        rd_chk("R9 new owner request cleared", 3, 8'hA4);
        wr_acc(0, 8'h20);
        check("R6 non-owner release keeps owner", int'(active_loc), 3);
        rd_chk("R6 own request cleared", 0, 8'h80);
        rd_chk("R6 owner pending dropped", 3, 8'hA0);
        wr_acc(3, 8'h20);
        check("R5 release with nobody waiting", int'(active_loc), 7);
        check("R11 no pulse when freed", int'(loc_chg), 0);
        rd_chk("R5 released reader", 3, 8'h80);
    endtask

    task automatic t_seize();
        wr_acc(0, 8'h02);
        check("R4 grant loc0", int'(active_loc), 0);
        wr_acc(2, 8'h0A);
        check("R7 seize by higher", int'(active_loc), 2);
        check("R11 pulse on seize", int'(loc_chg), 1);
        rd_chk("R2 seize hidden on read", 2, 8'hA0);
        rd_chk("R9 been-seized set", 0, 8'h90);
        wr_acc(1, 8'h0A);
        check("R7 lower seize refused", int'(active_loc), 2);
        rd_chk("R8 request bit ignored with seize", 1, 8'h80);
        wr_acc(0, 8'h10);
        rd_chk("R10 been-seized cleared", 0, 8'h80);
        wr_acc(2, 8'h20);
        check("R5 release loc2", int'(active_loc), 7);
        wr_acc(1, 8'h08);
        check("R7 seize when free", int'(active_loc), 1);
        rd_chk("R7 seize grant read", 1, 8'hA0);
        wr_acc(1, 8'h28);
        check("R8 release bit ignored with seize", int'(active_loc), 1);
        wr_acc(1, 8'h20);
        check("R5 release loc1", int'(active_loc), 7);
    endtask

    task automatic t_abort();
        wr_acc(0, 8'h02);
        cmd_busy = 1'b1;
        wr_acc(3, 8'h02);
        wr_acc(0, 8'h20);
        check("R13 abort raised", int'(abort_req), 1);
        check("R13 owner held during abort", int'(active_loc), 0);
        check("R13 no pulse yet", int'(loc_chg), 0);
        repeat (3) @(negedge clk);
        check("R13 abort held", int'(abort_req), 1);
        wr_acc(4, 8'h08, 1'b1);
        wr_acc(2, 8'h08);
        check("R13 still aborting", int'(abort_req), 1);
        abort_done = 1'b1;
        @(negedge clk);
        abort_done = 1'b0;
        check("R13 abort dropped", int'(abort_req), 0);
        check("R7 retargeted seize wins", int'(active_loc), 4);
        check("R11 pulse on completion", int'(loc_chg), 1);
        rd_chk("R9 seized old owner", 0, 8'h94);
        rd_chk("R9 new owner", 4, 8'hA4);
        rd_chk("R9 waiter keeps request", 3, 8'h82);
        cmd_busy = 1'b0;
        wr_acc(0, 8'h10);
        wr_acc(4, 8'h20, 1'b1);
        check("R5 release to waiter", int'(active_loc), 3);
        rd_chk("R9 released owner", 4, 8'h80);
        wr_acc(3, 8'h20);
        check("R5 release loc3", int'(active_loc), 7);
    endtask

    task automatic t_retarget();
        wr_acc(0, 8'h02);
        cmd_busy = 1'b1;
        wr_acc(2, 8'h08);
        check("R13 seize deferred", int'(abort_req), 1);
        wr_acc(3, 8'h08);
        abort_done = 1'b1;
        @(negedge clk);
        abort_done = 1'b0;
        check("R7 higher seize replaces lower", int'(active_loc), 3);
        rd_chk("R9 old owner seized", 0, 8'h90);
        rd_chk("R7 lower seizer not owner", 2, 8'h80);
        cmd_busy = 1'b0;
        wr_acc(0, 8'h10);
        wr_acc(3, 8'h20);
        check("R5 release after retarget", int'(active_loc), 7);
    endtask

    task automatic t_addr();
        wr_acc(4, 8'h02, 1'b0);
        check("R12 loc4 without hw ignored", int'(active_loc), 7);
        wr_acc(4, 8'h02, 1'b1);
        check("R12 loc4 with hw", int'(active_loc), 4);
        wr_acc(4, 8'h20, 1'b1);
        check("R12 loc4 release", int'(active_loc), 7);
        wr_acc(1, 8'h02, 1'b0, 12'h004);
        check("R14 non-zero offset ignored", int'(active_loc), 7);
        wr_acc(6, 8'h02);
        check("R12 locality 6 ignored", int'(active_loc), 7);
        wr_acc(2, 8'h02);
        check("R14 locality bits decode", int'(active_loc), 2);
        rd_chk("R14 owner read", 2, 8'hA0);
        rd_chk("R14 offset read", 2, 8'hFF, 12'h008);
        wr_acc(2, 8'h20);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grant_pending();
        t_release();
        t_seize();
        t_abort();
        t_retarget();
        t_addr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule